// File: doc/BRIEF.md
# EDO DRAM Controller with Distributed Refresh

This block sits between a synchronous requester and a 16 Mbit asynchronous DRAM organised as 4M words of 4 bits with extended-data-out page cycles. A requester presents one word at a time on a valid/ready handshake: a 22-bit word address, a direction bit and 4 bits of write data. The controller splits the address into a row half and a column half and drives them in turn on a shared address bus. It sequences the active-low row strobe, column strobe, write enable and output enable. Read data comes back as a one-cycle response pulse.

All device timing is given as nanosecond parameters per speed grade (50, 60 or 70). These are turned into whole clock counts by a ceiling divide against the clock period. When the next request continues the open row at the next column, in the same direction, the row strobe stays low and only a short page cycle runs. Refresh is distributed. A timer owes one column-before-row refresh at a time, and that refresh wins over new work at the next idle point.

Top module: `edo_dram_ctrl`

## Requirements
- R1: With `WIDE_ROW`=1 the row is address bits 21..10 and the column is bits 9..0. With `WIDE_ROW`=0 both halves are 11 bits (row 21..11, column 10..0). The row is on `dram_addr` when the row strobe falls, and the column is there when the column strobe falls.
- R2: During and right after reset, all four strobes are high (inactive), `dram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R3: A write drives its data on `dram_dq_out` with `dram_dq_oe`=1 and write enable low while the column strobe falls. A later read of the same word address returns that data on `rsp_data` with `rsp_valid`=1.
- R4: Read data is captured no earlier than the row access time (60 ns at grade 60) after the row strobe fell, and no earlier than the column access time (15 ns) after the column strobe fell.
- R5: Write enable and output enable are never low together. A read response is only produced from a cycle in which output enable, column strobe and row strobe were all still low.
- R6: Two falls of the row strobe are at least the random cycle time apart (104 ns at grade 60).
- R7: The row strobe stays high for at least the precharge time (40 ns at grade 60) before each fall.
- R8: A request that is the next word address in the same row, in the same direction, and arrives at the end of a column cycle is served by a new column cycle with the row strobe held low. Column strobe falls in one row are at least the page cycle time apart (25 ns at grade 60).
- R9: A row change, a non-consecutive address or a change of direction closes the row and opens a new one. No run holds more than `MAX_PAGE` (8) column cycles in one row.
- R10: A refresh lowers the column strobe at least one clock before the row strobe, with write enable high and no address needed.
- R11: Refreshes are no more than 15625 ns apart: 4096 rows in 64 ms, or 2048 rows in 32 ms.
- R12: An owed refresh blocks acceptance of new requests and page continuation until it has run. A second refresh never falls due while one is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 4 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data to the memory |
| dram_dq_oe | output | 1 | Controller drives the data lines |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
On every cycle the embedded properties check these rules: the minimum spacing of row-strobe falls, the precharge width, the column-before-row order of refresh, mutual exclusion of write and output enable, that read capture happens under active strobes, and that a refresh is never owed twice.

Only the scenarios can show the rest, run against a behavioural memory that stores data and times each pin event in nanoseconds. Those results are data integrity across both halves of the address split, reads of the correct value only once the access times are met, and whether page runs continue or break at row edges, at direction changes and at the run cap. They also cover the worst refresh gap under idle and under a saturating request stream.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int WIDE_ROW      = 1,
  parameter int SPEED         = 60,
  parameter int CLK_NS        = 10,
  parameter int MAX_PAGE      = 8,
  parameter int REF_MARGIN_NS = 2000,
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 4,
  parameter int ROW_W         = (WIDE_ROW != 0) ? 12 : 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [ROW_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  function automatic int grade(int s, int a, int b, int c);
    return (s <= 50) ? a : ((s <= 60) ? b : c);
  endfunction
  function automatic int clocks(int ns);
    int v;
    v = (ns + CLK_NS - 1) / CLK_NS;
    return (v < 1) ? 1 : v;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int COL_W   = ADDR_W - ROW_W;
  localparam int T_RC    = grade(SPEED, 84, 104, 124);
  localparam int T_RAC   = grade(SPEED, 50, 60, 70);
  localparam int T_CAC   = grade(SPEED, 13, 15, 20);
  localparam int T_HPC   = grade(SPEED, 20, 25, 30);
  localparam int T_RP    = grade(SPEED, 30, 40, 50);
  localparam int T_RCD   = grade(SPEED, 15, 20, 25);
  localparam int T_CSR   = 5;
  localparam int REFI_NS = (WIDE_ROW != 0) ? (64000000 / 4096) : (32000000 / 2048);

  localparam int RCD_CYC  = clocks(T_RCD);
  localparam int PCOL_CYC = clocks(T_CAC);
  localparam int FCOL_CYC = mx(PCOL_CYC, clocks(T_RAC) - RCD_CYC);
  localparam int HOLD_CYC = mx(1, clocks(T_HPC) - PCOL_CYC);
  localparam int RP_CYC   = clocks(T_RP);
  localparam int RC_CYC   = clocks(T_RC);
  localparam int RAS_CYC  = clocks(T_RC - T_RP);
  localparam int CSR_CYC  = clocks(T_CSR);
  localparam int REF_CYC  = clocks(REFI_NS - REF_MARGIN_NS);

  localparam int CNT_W = $clog2(mx(mx(RC_CYC, RAS_CYC), FCOL_CYC) + 2);
  localparam int RC_W  = $clog2(RC_CYC + 2);
  localparam int HI_W  = $clog2(RP_CYC + 2);
  localparam int REF_W = $clog2(REF_CYC + 1);
  localparam int PG_W  = $clog2(MAX_PAGE + 1);

  localparam logic [CNT_W-1:0] L_RCD  = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] L_FCOL = CNT_W'(FCOL_CYC - 1);
  localparam logic [CNT_W-1:0] L_PCOL = CNT_W'(PCOL_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] L_RP   = CNT_W'(RP_CYC - 1);
  localparam logic [CNT_W-1:0] L_RAS  = CNT_W'(RAS_CYC - 1);
  localparam logic [CNT_W-1:0] L_CSR  = CNT_W'(CSR_CYC - 1);
  localparam logic [RC_W-1:0]  L_RC   = RC_W'(RC_CYC - 1);
  localparam logic [RC_W-1:0]  RC_SAT = RC_W'(RC_CYC);
  localparam logic [HI_W-1:0]  HI_SAT = HI_W'(RP_CYC);
  localparam logic [REF_W-1:0] L_REF  = REF_W'(REF_CYC - 1);
  localparam logic [PG_W-1:0]  L_PG   = PG_W'(MAX_PAGE - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_HOLD, S_PRE, S_CBR_CAS, S_CBR_RAS
  } state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [RC_W-1:0]     rc_cnt;
  logic [REF_W-1:0]    ref_cnt;
  logic                ref_pending;
  logic [PG_W-1:0]     page_cnt;
  logic                paged;
  logic                cur_wr;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_data;

  wire [ROW_W-1:0] cur_row   = cur_addr[ADDR_W-1 -: ROW_W];
  wire [COL_W-1:0] cur_col   = cur_addr[COL_W-1:0];
  wire             ref_tick  = (ref_cnt == L_REF);
  wire             col_last  = (cnt == (paged ? L_PCOL : L_FCOL));
  wire             hold_last = (cnt == L_HOLD);
  wire             same_row  = (req_addr[ADDR_W-1 -: ROW_W] == cur_row);
  wire             next_word = (req_addr == cur_addr + ADDR_W'(1));
  wire             page_ok   = !ref_pending && same_row && next_word &&
                               (req_write == cur_wr) && (page_cnt < L_PG);
  wire             accept    = req_valid && req_ready;
  wire             ras_fall  = (state == S_IDLE && !ref_pending && req_valid) ||
                               (state == S_CBR_CAS && cnt == L_CSR);

  assign req_ready  = (state == S_IDLE && !ref_pending) ||
                      (state == S_HOLD && hold_last && page_ok);
  assign dram_ras_n = !(state == S_ROW || state == S_COL || state == S_HOLD ||
                        state == S_CBR_RAS);
  assign dram_cas_n = !(state == S_COL || state == S_CBR_CAS || state == S_CBR_RAS);
  assign dram_we_n  = !(state == S_COL && cur_wr);
  assign dram_oe_n  = !(state == S_COL && !cur_wr);
  assign dram_dq_oe = (state == S_COL) && cur_wr;
  assign dram_dq_out = cur_data;
  assign dram_addr  = (state == S_ROW) ? cur_row : ROW_W'(cur_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt     <= '0;
      ref_pending <= 1'b0;
    end else begin
      ref_cnt <= ref_tick ? '0 : ref_cnt + REF_W'(1);
      if (ref_tick)
        ref_pending <= 1'b1;
      else if (state == S_IDLE && ref_pending)
        ref_pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rc_cnt <= RC_SAT;
    else if (ras_fall)
      rc_cnt <= '0;
    else if (rc_cnt != RC_SAT)
      rc_cnt <= rc_cnt + RC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (state == S_COL) && col_last && !cur_wr;
      if ((state == S_COL) && col_last && !cur_wr)
        rsp_data <= dram_dq_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      page_cnt <= '0;
      paged    <= 1'b0;
      cur_wr   <= 1'b0;
      cur_addr <= '0;
      cur_data <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (accept) begin
        cur_wr   <= req_write;
        cur_addr <= req_addr;
        cur_data <= req_wdata;
      end
      unique case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pending) state <= S_CBR_CAS;
          else if (req_valid) begin
            state    <= S_ROW;
            paged    <= 1'b0;
            page_cnt <= '0;
          end
        end
        S_ROW: if (cnt == L_RCD) begin
          state <= S_COL;
          cnt   <= '0;
        end
        S_COL: if (col_last) begin
          state <= S_HOLD;
          cnt   <= '0;
        end
        S_HOLD: if (hold_last) begin
          cnt <= '0;
          if (accept) begin
            state    <= S_COL;
            paged    <= 1'b1;
            page_cnt <= page_cnt + PG_W'(1);
          end else
            state <= S_PRE;
        end
        S_PRE: begin
          if (cnt >= L_RP) cnt <= cnt;
          if (cnt >= L_RP && rc_cnt >= L_RC) begin
            state <= S_IDLE;
            cnt   <= '0;
          end
        end
        S_CBR_CAS: if (cnt == L_CSR) begin
          state <= S_CBR_RAS;
          cnt   <= '0;
        end
        S_CBR_RAS: if (cnt == L_RAS) begin
          state <= S_PRE;
          cnt   <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [HI_W-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)
      hi_cnt <= HI_SAT;
    else if (!dram_ras_n)
      hi_cnt <= '0;
    else if (hi_cnt != HI_SAT)
      hi_cnt <= hi_cnt + HI_W'(1);
  end

  // R6
  rc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(rc_cnt) >= L_RC);

  // R7
  precharge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(hi_cnt) >= HI_W'(RP_CYC - 1));

  // R10
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n));

  // R5
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n));

  // R5
  capture_under_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!dram_oe_n && !dram_cas_n && !dram_ras_n));

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_tick && ref_pending));

endmodule

// File: tb/edo_dram_ctrl_test.sv
module edo_dram_ctrl_test;
  localparam int ROW_W = 12;
  localparam int COL_W = 10;
  localparam int TCK = 10;
  localparam int T_RC = 104, T_RAC = 60, T_CAC = 15, T_HPC = 25, T_RP = 40;
  localparam int T_REFI = 15625;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [3:0] rsp_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0] daddr;
  logic [3:0] dq_out;
  logic [3:0] dq_in = '0;

  edo_dram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(daddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  always #5 clk = ~clk;

  int vecs = 0, errs = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural memory with nanosecond rule checks
  logic [3:0] mem [int];
  logic [ROW_W-1:0] m_row;
  bit p_ras = 1, p_cas = 1, have_ras = 0, have_ref = 0;
  int t_rasf = 0, t_rasr = -1000, t_casf = 0, t_ref = 0;
  int cas_in_row = 0;
  int n_open = 0, n_page = 0, n_ref = 0;
  int v_rc = 0, v_rp = 0, v_hpc = 0, v_cbr = 0, v_weoe = 0, v_dq = 0, v_refi = 0;

  always @(negedge clk) begin
    int t;
    int key;
    t = cyc * TCK;
    if (!rst_n) begin
      p_ras = ras_n; p_cas = cas_n;
    end else begin
      if (!we_n && !oe_n) v_weoe++;
      if (p_ras && !ras_n) begin
        if (have_ras && t - t_rasf < T_RC) v_rc++;
        if (t - t_rasr < T_RP) v_rp++;
        have_ras = 1; t_rasf = t; cas_in_row = 0;
        if (!cas_n) begin
          if (p_cas || !we_n) v_cbr++;
          if (have_ref && t - t_ref > T_REFI) v_refi++;
          have_ref = 1; t_ref = t; n_ref++;
        end else begin
          m_row = daddr; n_open++;
        end
      end
      if (!p_ras && ras_n) t_rasr = t;
      if (!ras_n && p_cas && !cas_n && !p_ras) begin
        key = int'({m_row, daddr[COL_W-1:0]});
        if (cas_in_row > 0) begin
          n_page++;
          if (t - t_casf < T_HPC) v_hpc++;
        end
        cas_in_row++; t_casf = t;
        if (!we_n) begin
          if (!dq_oe) v_dq++;
          mem[key] = dq_out;
        end
      end
      if (!ras_n && !cas_n && !oe_n && we_n) begin
        key = int'({m_row, daddr[COL_W-1:0]});
        if ((t - t_casf + TCK >= T_CAC) && (t - t_rasf + TCK >= T_RAC))
          dq_in <= mem.exists(key) ? mem[key] : 4'h0;
        else
          dq_in <= mem.exists(key) ? ~mem[key] : 4'hF;
      end else
        dq_in <= 4'h0;
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  // expected read data, in issue order
  int exq[$];
  int n_rsp = 0, n_rd = 0;
  always @(negedge clk) begin
    int e;
    if (rst_n && rsp_valid) begin
      n_rsp++;
      if (exq.size() == 0) check(0, "R3 unexpected response", rsp_data, 0);
      else begin
        e = exq.pop_front();
        check(rsp_data == 4'(e), "R3/R4 read data", rsp_data, e);
      end
    end
  end

  logic [3:0] shadow [int];

  task automatic send(input bit w, input logic [21:0] a, input logic [3:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (w) shadow[int'(a)] = d;
    else begin exq.push_back(int'(d)); n_rd++; end
    @(negedge clk);
    req_valid = 0;
  endtask

  function automatic logic [3:0] expect_at(input logic [21:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0;
  endfunction

  task automatic drain();
    int k = 0;
    while ((exq.size() != 0 || ras_n == 0) && k < 2000) begin @(negedge clk); k++; end
    repeat (20) @(negedge clk);
  endtask

  task automatic sync_refresh();
    int r;
    r = n_ref;
    while (n_ref == r) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // {write, addr, data}; for reads data is the expected value
  localparam logic [26:0] VEC [16] = '{
    {1'b1, 22'h000000, 4'h5}, {1'b1, 22'h3FFFFF, 4'hA},
    {1'b1, 22'h000400, 4'h3}, {1'b1, 22'h0003FF, 4'hC},
    {1'b0, 22'h000000, 4'h5}, {1'b0, 22'h3FFFFF, 4'hA},
    {1'b1, 22'h155555, 4'h9}, {1'b0, 22'h000400, 4'h3},
    {1'b0, 22'h0003FF, 4'hC}, {1'b1, 22'h2AAAAA, 4'h6},
    {1'b0, 22'h155555, 4'h9}, {1'b0, 22'h2AAAAA, 4'h6},
    {1'b1, 22'h123456, 4'hF}, {1'b0, 22'h123456, 4'hF},
    {1'b1, 22'h000000, 4'h1}, {1'b0, 22'h000000, 4'h1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int o0, p0, r0;
    logic [21:0] b;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(ras_n && cas_n && we_n && oe_n, "R2 strobes in reset", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    check(!dq_oe && !rsp_valid, "R2 dq_oe/rsp_valid in reset", {dq_oe, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R2 ready after reset", req_ready, 1);
    check(ras_n && cas_n, "R2 strobes idle after reset", {ras_n, cas_n}, 3);

    // table: alternating rows/directions, no page hits (R1, R3, R4, R9)
    sync_refresh();
    o0 = n_open;
    foreach (VEC[i]) send(VEC[i][26], VEC[i][25:4], VEC[i][3:0]);
    drain();
    check(n_open - o0 == 16, "R9 one row open per table access", n_open - o0, 16);
    check(mem.exists(int'(22'h3FFFFF)) && mem[int'(22'h3FFFFF)] == 4'hA, "R1 row/column split top word",
          mem.exists(int'(22'h3FFFFF)) ? int'(mem[int'(22'h3FFFFF)]) : -1, 4'hA);
    check(mem.exists(int'(22'h123456)) && mem[int'(22'h123456)] == 4'hF, "R1 row/column split mid word",
          mem.exists(int'(22'h123456)) ? int'(mem[int'(22'h123456)]) : -1, 4'hF);

    // R8/R9: page runs capped at MAX_PAGE (8)
    sync_refresh();
    b = 22'h0ABC00;
    o0 = n_open; p0 = n_page;
    for (int i = 0; i < 10; i++) send(1, b + 22'(i), 4'((i * 3 + 1) & 15));
    for (int i = 0; i < 10; i++) send(0, b + 22'(i), expect_at(b + 22'(i)));
    drain();
    check(n_open - o0 == 4, "R9 page run capped at 8", n_open - o0, 4);
    check(n_page - p0 == 16, "R8 page column cycles", n_page - p0, 16);

    // R9: consecutive address crossing a row edge
    sync_refresh();
    o0 = n_open; p0 = n_page;
    send(1, 22'h0007FF, 4'h7);
    send(1, 22'h000800, 4'h8);
    send(0, 22'h0007FF, 4'h7);
    send(0, 22'h000800, 4'h8);
    drain();
    check(n_open - o0 == 4, "R9 row edge breaks page", n_open - o0, 4);
    check(n_page - p0 == 0, "R9 no page cycle across rows", n_page - p0, 0);
    check(mem.exists(int'(22'h000800)) && mem[int'(22'h000800)] == 4'h8, "R1 first column of next row",
          mem.exists(int'(22'h000800)) ? int'(mem[int'(22'h000800)]) : -1, 8);

    // R12: saturating page reads still let refresh in
    r0 = n_ref;
    for (int k = 0; k < 60; k++)
      for (int i = 0; i < 8; i++) send(0, b + 22'(i), expect_at(b + 22'(i)));
    drain();
    check(n_ref - r0 >= 1, "R12 refresh wins over request stream", n_ref - r0, 1);

    // R11: idle refresh rate
    r0 = n_ref;
    repeat (20000) @(negedge clk);
    check(n_ref - r0 >= 12, "R11 refreshes in 200 us idle", n_ref - r0, 12);

    check(n_rsp == n_rd, "R3 one response per read", n_rsp, n_rd);
    check(v_rc == 0, "R6 row cycle time", v_rc, 0);
    check(v_rp == 0, "R7 precharge time", v_rp, 0);
    check(v_hpc == 0, "R8 page cycle time", v_hpc, 0);
    check(v_cbr == 0, "R10 refresh strobe order", v_cbr, 0);
    check(v_weoe == 0, "R5 write/output enable overlap", v_weoe, 0);
    check(v_dq == 0, "R3 data driven during write", v_dq, 0);
    check(v_refi == 0, "R11 refresh gap", v_refi, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule